// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is the integer register file of a load/store core that hands every procedure activation a private window of registers. A 5-bit logical register number is translated through the current window pointer into a physical register. A shared group of globals sits at the bottom of the logical space. Each window owns an incoming-argument group and a local group. Its outgoing-argument group is physically the incoming-argument group of the next window, so a caller writes arguments and the callee finds them without any copying.

The file has two read ports and one write port. A call input advances the window pointer and a return input moves it back, both modulo the window count. A second pointer marks the window that is not resident. When a call or a return lands the current pointer on it, the block raises an overflow or underflow trap and freezes the pointers. A trap handler then moves that window to or from memory through a narrow side port and acknowledges. The acknowledge advances or retreats the save pointer and clears the trap.

Top module: `winreg_file`

## Requirements
- R1: Logical registers 0 to 9 are globals and map to physical registers 0 to 9 whatever the current window.
- R2: In window w (the value of `cur_win`), logical 10..15 map to physical 10+16w+(r-10), logical 16..25 map to physical 10+16w+(r-10), and logical 26..31 map to physical 10+16((w+1) mod 8)+(r-26). Outgoing registers of window w are therefore the incoming registers of window w+1. Reads and writes use the window in force before any pointer move in the same cycle. Read data appears on `rd1`/`rd2` one clock after the address.
- R3: A write to logical register 0 is discarded, and a read of logical register 0 returns zero.
- R4: A read of the physical register being written in the same cycle returns the new data.
- R5: With no trap pending, `call` alone sets `cur_win` to `cur_win`+1 mod 8 and `ret` alone sets it to `cur_win`-1 mod 8, visible one clock later.
- R6: `ovf_trap` rises when an accepted call makes `cur_win` equal `save_win`. From reset, seven nested calls complete without a trap and the eighth traps.
- R7: `unf_trap` rises when an accepted return makes `cur_win` equal `save_win`.
- R8: While a trap is pending, `call` and `ret` are ignored and both pointers hold. A `trap_ack` clears the trap. It increments `save_win` after an overflow and decrements it after an underflow. At most one trap is high at a time.
- R9: Side port index i (0..15) selects physical register 10+16·`save_win`+i. `sp_rd` returns it one clock later. `sp_we` writes it only while a trap is pending, and in that case it takes precedence over a main-port write in the same cycle.
- R10: `call` and `ret` asserted together have no effect.
- R11: After reset `cur_win` and `save_win` are 0, both traps are low and both read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra1 | input | 5 | Logical read address, port 1 |
| ra2 | input | 5 | Logical read address, port 2 |
| rd1 | output | 32 | Registered read data, port 1 |
| rd2 | output | 32 | Registered read data, port 2 |
| we | input | 1 | Main write enable |
| wa | input | 5 | Logical write address |
| wd | input | 32 | Write data |
| call | input | 1 | Procedure call: advance window |
| ret | input | 1 | Procedure return: retreat window |
| trap_ack | input | 1 | Handler finished spill or fill |
| ovf_trap | output | 1 | Window overflow pending |
| unf_trap | output | 1 | Window underflow pending |
| cur_win | output | 3 | Current window pointer |
| save_win | output | 3 | Save window pointer |
| sp_idx | input | 4 | Side port register index within save window |
| sp_we | input | 1 | Side port write enable |
| sp_wd | input | 32 | Side port write data |
| sp_rd | output | 32 | Side port registered read data |

## Verification
The two functions that can share a cycle are the write-first bypass and a window move. The bench issues a call together with a write and a read of the same local register. It then judges that the read returns the new data and that the write landed in the pre-call window, which it confirms after returning. The other coincidences are a call together with a return, which must leave the pointer unchanged, and a side write outside a trap, which must leave the stored value unchanged when read back through the side port. Expected values come from an arithmetic model of the window mapping, applied to a sweep over every logical register in every window.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  typedef enum logic [1:0] {
    TRAP_IDLE = 2'd0,
    TRAP_OVF  = 2'd1,
    TRAP_UNF  = 2'd2
  } trap_state_e;
endpackage

// File: rtl/winreg_map.sv
// Logical-to-physical translation for one register port.
module winreg_map #(
  parameter int NGLOB = 10,
  parameter int NIN   = 6,
  parameter int NLOC  = 10,
  parameter int NWIN  = 8,
  parameter int LRW   = 5,
  parameter int WPW   = 3,
  parameter int PW    = 8
) (
  input  logic [LRW-1:0] lreg,
  input  logic [WPW-1:0] win,
  output logic [PW-1:0]  phys
);
  localparam int NSLOT = NIN + NLOC;

  logic [WPW-1:0] win_nxt;
  int             li;
  int             pi;

  always_comb begin
    win_nxt = win + 1'b1;
    li      = int'(lreg);
    if (li < NGLOB)
      pi = li;
    else if (li < NGLOB + NSLOT)
      pi = NGLOB + int'(win) * NSLOT + (li - NGLOB);
    else
      pi = NGLOB + int'(win_nxt) * NSLOT + (li - NGLOB - NSLOT);
    phys = PW'(pi);
  end
endmodule

// File: rtl/winreg_ptr.sv
// Current/save window pointers and trap sequencing.
module winreg_ptr
  import winreg_pkg::*;
#(
  parameter int WPW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call,
  input  logic           ret,
  input  logic           trap_ack,
  output logic [WPW-1:0] cwp,
  output logic [WPW-1:0] swp,
  output logic           ovf,
  output logic           unf
);
  trap_state_e    state;
  logic [WPW-1:0] cwp_up;
  logic [WPW-1:0] cwp_dn;

  assign cwp_up = cwp + 1'b1;
  assign cwp_dn = cwp - 1'b1;
  assign ovf    = (state == TRAP_OVF);
  assign unf    = (state == TRAP_UNF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp   <= '0;
      swp   <= '0;
      state <= TRAP_IDLE;
    end else if (state != TRAP_IDLE) begin
      if (trap_ack) begin
        if (state == TRAP_OVF) swp <= swp + 1'b1;
        else                   swp <= swp - 1'b1;
        state <= TRAP_IDLE;
      end
    end else if (call && !ret) begin
      cwp <= cwp_up;
      if (cwp_up == swp) state <= TRAP_OVF;
    end else if (ret && !call) begin
      cwp <= cwp_dn;
      if (cwp_dn == swp) state <= TRAP_UNF;
    end
  end
endmodule

// File: rtl/winreg_store.sv
// Physical storage: one write port, NRP registered read ports, write-first.
module winreg_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 138,
  parameter int PW    = 8,
  parameter int NRP   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [PW-1:0] ra   [NRP],
  input  logic          rz   [NRP],
  output logic [DW-1:0] rd   [NRP]
);
  logic [DW-1:0] cells [NPHYS];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    always_ff @(posedge clk) begin
      if (rst || rz[p])
        rd[p] <= '0;
      else if (we && (wa == ra[p]))
        rd[p] <= wd;
      else
        rd[p] <= cells[ra[p]];
    end
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int DW    = 32,
  parameter int NGLOB = 10,
  parameter int NIN   = 6,
  parameter int NLOC  = 10,
  parameter int NWIN  = 8,
  localparam int NSLOT = NIN + NLOC,
  localparam int NPHYS = NGLOB + NWIN * NSLOT,
  localparam int PW    = $clog2(NPHYS),
  localparam int LRW   = $clog2(NGLOB + NSLOT + NIN),
  localparam int WPW   = $clog2(NWIN),
  localparam int SIW   = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LRW-1:0] ra1,
  input  logic [LRW-1:0] ra2,
  output logic [DW-1:0]  rd1,
  output logic [DW-1:0]  rd2,
  input  logic           we,
  input  logic [LRW-1:0] wa,
  input  logic [DW-1:0]  wd,
  input  logic           call,
  input  logic           ret,
  input  logic           trap_ack,
  output logic           ovf_trap,
  output logic           unf_trap,
  output logic [WPW-1:0] cur_win,
  output logic [WPW-1:0] save_win,
  input  logic [SIW-1:0] sp_idx,
  input  logic           sp_we,
  input  logic [DW-1:0]  sp_wd,
  output logic [DW-1:0]  sp_rd
);
  localparam int NMAP = 3;  // ra1, ra2, wa
  localparam int NRP  = 3;  // ra1, ra2, side

  logic [LRW-1:0] lreg [NMAP];
  logic [PW-1:0]  phys [NMAP];
  logic [PW-1:0]  side_phys;
  logic           pending;
  logic           side_wr;
  logic           main_wr;
  logic           mem_we;
  logic [PW-1:0]  mem_wa;
  logic [DW-1:0]  mem_wd;
  logic [PW-1:0]  rp_addr [NRP];
  logic           rp_zero [NRP];
  logic [DW-1:0]  rp_data [NRP];

  winreg_ptr #(.WPW(WPW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .call     (call),
    .ret      (ret),
    .trap_ack (trap_ack),
    .cwp      (cur_win),
    .swp      (save_win),
    .ovf      (ovf_trap),
    .unf      (unf_trap)
  );

  assign lreg[0] = ra1;
  assign lreg[1] = ra2;
  assign lreg[2] = wa;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    winreg_map #(
      .NGLOB(NGLOB), .NIN(NIN), .NLOC(NLOC), .NWIN(NWIN),
      .LRW(LRW), .WPW(WPW), .PW(PW)
    ) u_map (
      .lreg (lreg[m]),
      .win  (cur_win),
      .phys (phys[m])
    );
  end

  assign pending   = ovf_trap | unf_trap;
  assign side_phys = PW'(NGLOB + int'(save_win) * NSLOT + int'(sp_idx));
  assign side_wr   = sp_we && pending;
  assign main_wr   = we && (wa != '0);
  assign mem_we    = side_wr || main_wr;
  assign mem_wa    = side_wr ? side_phys : phys[2];
  assign mem_wd    = side_wr ? sp_wd : wd;

  assign rp_addr[0] = phys[0];
  assign rp_addr[1] = phys[1];
  assign rp_addr[2] = side_phys;
  assign rp_zero[0] = (ra1 == '0);
  assign rp_zero[1] = (ra2 == '0);
  assign rp_zero[2] = 1'b0;

  winreg_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRP(NRP)) u_store (
    .clk (clk),
    .rst (rst),
    .we  (mem_we),
    .wa  (mem_wa),
    .wd  (mem_wd),
    .ra  (rp_addr),
    .rz  (rp_zero),
    .rd  (rp_data)
  );

  assign rd1   = rp_data[0];
  assign rd2   = rp_data[1];
  assign sp_rd = rp_data[2];
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int DW  = 32,
  parameter int LRW = 5,
  parameter int WPW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           call,
  input logic           ret,
  input logic           trap_ack,
  input logic [LRW-1:0] ra1,
  input logic [DW-1:0]  rd1,
  input logic           ovf_trap,
  input logic           unf_trap,
  input logic [WPW-1:0] cur_win,
  input logic [WPW-1:0] save_win
);
  // R5
  call_step_chk: assert property (@(posedge clk) disable iff (rst)
    (call && !ret && !ovf_trap && !unf_trap) |=> cur_win == WPW'($past(cur_win) + 1'b1));
  // R5
  ret_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !call && !ovf_trap && !unf_trap) |=> cur_win == WPW'($past(cur_win) - 1'b1));
  // R6
  ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (call && !ret && !ovf_trap && !unf_trap && (WPW'(cur_win + 1'b1) == save_win)) |=> ovf_trap);
  // R7
  unf_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !call && !ovf_trap && !unf_trap && (WPW'(cur_win - 1'b1) == save_win)) |=> unf_trap);
  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovf_trap || unf_trap) && !trap_ack) |=> ($stable(cur_win) && $stable(save_win)));
  // R8
  ovf_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_trap && trap_ack) |=> (!ovf_trap && save_win == WPW'($past(save_win) + 1'b1)));
  // R8
  trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_trap, unf_trap}));
  // R10
  both_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (call && ret && !ovf_trap && !unf_trap) |=> $stable(cur_win));
  // R3
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ra1 == '0) |=> (rd1 == '0));
endmodule

bind winreg_file winreg_file_chk #(.DW(DW), .LRW(LRW), .WPW(WPW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .call     (call),
  .ret      (ret),
  .trap_ack (trap_ack),
  .ra1      (ra1),
  .rd1      (rd1),
  .ovf_trap (ovf_trap),
  .unf_trap (unf_trap),
  .cur_win  (cur_win),
  .save_win (save_win)
);

// File: tb/winreg_file_tb.sv
module winreg_file_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ra1 = '0, ra2 = '0, wa = '0;
  logic [31:0] rd1, rd2, wd = '0, sp_wd = '0, sp_rd;
  logic        we = 1'b0, call = 1'b0, ret = 1'b0, trap_ack = 1'b0, sp_we = 1'b0;
  logic        ovf_trap, unf_trap;
  logic [2:0]  cur_win, save_win;
  logic [3:0]  sp_idx = '0;

  int nchk = 0;
  int nerr = 0;
  int cw   = 0;
  bit done = 1'b0;
  logic [31:0] model [138];

  always #2 clk = ~clk;

  winreg_file u_dut (
    .clk(clk), .rst(rst), .ra1(ra1), .ra2(ra2), .rd1(rd1), .rd2(rd2),
    .we(we), .wa(wa), .wd(wd), .call(call), .ret(ret), .trap_ack(trap_ack),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap), .cur_win(cur_win),
    .save_win(save_win), .sp_idx(sp_idx), .sp_we(sp_we), .sp_wd(sp_wd),
    .sp_rd(sp_rd)
  );

  function automatic int pmap(int w, int r);
    if (r < 10) return r;
    if (r < 26) return 10 + w * 16 + (r - 10);
    return 10 + ((w + 1) % 8) * 16 + (r - 26);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int r, logic [31:0] v);
    we = 1'b1; wa = 5'(r); wd = v; ra1 = 5'(r);
    tick();
    we = 1'b0;
    if (r == 0) chk("R3 write r0", rd1, 32'h0);
    else begin
      chk("R4 bypass", rd1, v);
      model[pmap(cw, r)] = v;
    end
  endtask

  task automatic rdchk(int r);
    ra1 = 5'(r); ra2 = 5'(31 - r);
    tick();
    chk(r < 10 ? "R1 global" : (r == 0 ? "R3" : "R2 window"), rd1,
        r == 0 ? 32'h0 : model[pmap(cw, r)]);
    chk((31 - r) < 10 ? "R1 global" : "R2 window", rd2, model[pmap(cw, 31 - r)]);
  endtask

  task automatic do_call();
    call = 1'b1; tick(); call = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 138; i++) model[i] = 32'h0;
    repeat (3) tick();
    rst = 1'b0;
    // R11 reset state
    chk("R11 rd1", rd1, 0);
    chk("R11 rd2", rd2, 0);
    chk("R11 ovf", 32'(ovf_trap), 0);
    chk("R11 unf", 32'(unf_trap), 0);
    chk("R11 cur_win", 32'(cur_win), 0);
    chk("R11 save_win", 32'(save_win), 0);

    // Write every logical register of every window (R1 R2 R3 R4 R5 R6)
    for (int w = 0; w < 8; w++) begin
      for (int r = 0; r < 32; r++) wr(r, 32'hA000_0000 | 32'(w << 8) | 32'(r));
      if (w < 7) begin
        do_call(); cw++;
        chk("R5 call step", 32'(cur_win), 32'(cw));
        chk("R6 no early ovf", 32'(ovf_trap), 0);
      end
    end
    // Read back while returning (R1 R2 R5 R7)
    for (int w = 7; w >= 1; w--) begin
      for (int r = 0; r < 32; r++) rdchk(r);
      if (w > 1) begin
        do_ret(); cw--;
        chk("R5 ret step", 32'(cur_win), 32'(cw));
        chk("R7 no early unf", 32'(unf_trap), 0);
      end
    end

    // Overflow (R6 R8 R9)
    for (int k = 0; k < 6; k++) begin
      do_call(); cw++;
      chk("R6 no ovf", 32'(ovf_trap), 0);
    end
    do_call(); cw = 0;
    chk("R6 ovf raised", 32'(ovf_trap), 1);
    chk("R6 cur_win wrap", 32'(cur_win), 0);
    do_call();
    chk("R8 call ignored", 32'(cur_win), 0);
    for (int i = 0; i < 16; i++) begin
      sp_idx = 4'(i); tick();
      chk("R9 spill read", sp_rd, model[10 + i]);
    end
    trap_ack = 1'b1; tick(); trap_ack = 1'b0;
    chk("R8 ovf cleared", 32'(ovf_trap), 0);
    chk("R8 save_win inc", 32'(save_win), 1);

    // Underflow (R7 R8 R9)
    for (int k = 0; k < 6; k++) begin
      do_ret(); cw = (cw + 7) % 8;
      chk("R7 no unf", 32'(unf_trap), 0);
    end
    do_ret(); cw = 1;
    chk("R7 unf raised", 32'(unf_trap), 1);
    chk("R7 cur_win", 32'(cur_win), 1);
    do_ret();
    chk("R8 ret ignored", 32'(cur_win), 1);
    for (int i = 0; i < 16; i++) begin
      sp_we = 1'b1; sp_idx = 4'(i); sp_wd = 32'h5A00_0000 | 32'(i);
      tick();
      model[26 + i] = 32'h5A00_0000 | 32'(i);
    end
    sp_we = 1'b0;
    trap_ack = 1'b1; tick(); trap_ack = 1'b0;
    chk("R8 unf cleared", 32'(unf_trap), 0);
    chk("R8 save_win dec", 32'(save_win), 0);
    for (int r = 10; r < 26; r++) rdchk(r);

    // Side write outside a trap is ignored (R9)
    sp_we = 1'b1; sp_idx = 4'd0; sp_wd = 32'hDEAD_BEEF; tick(); sp_we = 1'b0;
    tick();
    chk("R9 side write ignored", sp_rd, model[10]);

    // Call and return together (R10)
    call = 1'b1; ret = 1'b1; tick(); call = 1'b0; ret = 1'b0;
    chk("R10 cur_win held", 32'(cur_win), 1);
    chk("R10 no trap", 32'({ovf_trap, unf_trap}), 0);

    // Write + read in the call cycle use the old window (R2 R4 R5)
    call = 1'b1; we = 1'b1; wa = 5'd16; wd = 32'hC0FF_EE01; ra1 = 5'd16;
    tick();
    call = 1'b0; we = 1'b0;
    chk("R4 bypass in call", rd1, 32'hC0FF_EE01);
    chk("R5 call with write", 32'(cur_win), 2);
    model[pmap(1, 16)] = 32'hC0FF_EE01;
    cw = 2;
    do_ret(); cw = 1;
    rdchk(16);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule